// File: doc/BRIEF.md
# Seconds-Based Watchdog Timer With Selectable Expiry Action

This block is a watchdog peripheral behind a small register window. Software puts a timeout, in whole seconds, into a count register. It then sets a run bit and must write a trigger bit again and again to restart the countdown. If software stops writing the trigger for longer than the timeout, the countdown reaches zero. The block then raises a one-cycle request to reset the system or to power it off. A control bit chooses which of the two.

A parameterised prescaler divides the input clock into one pulse per second. The countdown steps only on that pulse, and only while the run bit is set and the external inhibit input is low. A sticky flag records that the last restart came from the watchdog. The flag sits in the power-on reset domain, so the system reset that the watchdog itself causes does not clear it. Software clears the flag by writing 1 to it.

Top module: `sec_watchdog`

## Requirements
- R1: After `rst` and `por_rst`, the control word reads 0 (with `tmr_inhibit` low), the count register reads RST_TIMEOUT (60 by default), and both request outputs are low.
- R2: Address bit 2 selects the register: 0 selects control and 1 selects count. Count is 10 bits wide, and its upper bits read 0. Control bit 0 is run and bit 2 is the action; both read back as written. All control bits other than 0 to 3 read 0.
- R3: A control write with bit 7 set reloads the countdown from the count register and restarts the second prescaler. Bit 7 always reads 0. A trigger written while run is 0 only reloads, and no request follows.
- R4: While run is 1 and inhibit is low, the countdown drops by one every TICK_CYCLES clocks. A trigger that loads N captured at edge W gives a request pulse exactly one cycle long, starting at edge W + N*TICK_CYCLES.
- R5: Action bit 2 = 0 makes an expiry drive `rst_req`. Action bit 2 = 1 makes it drive `pwroff_req`. The two outputs are never high together.
- R6: Clearing run freezes the remaining count and clears the prescaler. Setting run again resumes from the frozen count, with a full second before the next step.
- R7: While `tmr_inhibit` is high, control bit 3 reads 1 and the countdown and prescaler are frozen.
- R8: An expiry sets control bit 1 one cycle after the request. The flag survives `rst`. It is cleared only by `por_rst` or by a control write with bit 1 set; a write with bit 1 = 0 leaves it unchanged.
- R9: A trigger that loads a count of 0 never produces a request.
- R10: Triggers repeated at intervals shorter than the timeout keep both request outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high watchdog reset (leaves the fired flag alone) |
| por_rst | input | 1 | Synchronous active-high power-on reset for the fired flag |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address in the window; bit 2 selects the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register selected by `bus_addr` |
| tmr_inhibit | input | 1 | Holds the timer disabled while high |
| rst_req | output | 1 | One-cycle system reset request on expiry |
| pwroff_req | output | 1 | One-cycle power-off request on expiry |

## Verification
On every cycle the assertions check four things: the two request outputs are mutually exclusive single-cycle pulses, a request only follows a cycle in which the timer was active, a trigger lands the count register value in the countdown, and the countdown holds still whenever the timer is stopped or inhibited. They also check that every request sets the fired flag. Only the bench scenarios can show the exact expiry cycle for a given timeout. The same goes for the resume timing after a stop or an inhibit, the flag surviving `rst` while `por_rst` and write-one clear remove it, and periodic triggering or a zero load keeping the outputs quiet.

// File: rtl/swd_pkg.sv
`timescale 1ns/1ps
package swd_pkg;
    localparam int REG_W     = 32;
    localparam int RUN_BIT   = 0;
    localparam int FIRED_BIT = 1;
    localparam int ACT_BIT   = 2;
    localparam int INH_BIT   = 3;
    localparam int KICK_BIT  = 7;
    localparam int SEL_BIT   = 2;   // address bit choosing the count register

    typedef enum logic {
        ACT_RESET    = 1'b0,
        ACT_POWEROFF = 1'b1
    } expiry_act_e;

    typedef struct packed {
        logic        run;
        expiry_act_e act;
    } ctrl_t;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_load;
        logic kick;
        logic clr_fired;
    } bus_cmd_t;

    function automatic bus_cmd_t decode_write(logic wen, logic sel_load,
                                              logic kick_bit, logic fired_bit);
        bus_cmd_t c;
        c.wr_ctrl   = wen && !sel_load;
        c.wr_load   = wen && sel_load;
        c.kick      = c.wr_ctrl && kick_bit;
        c.clr_fired = c.wr_ctrl && fired_bit;
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(ctrl_t c, logic fired, logic inh);
        logic [REG_W-1:0] v;
        v            = '0;
        v[RUN_BIT]   = c.run;
        v[FIRED_BIT] = fired;
        v[ACT_BIT]   = c.act;
        v[INH_BIT]   = inh;
        return v;
    endfunction
endpackage

// File: rtl/swd_prescale.sv
`timescale 1ns/1ps
module swd_prescale #(
    parameter int TICK_CYCLES = 125_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] phase_q;

    assign tick = active && (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || !active || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/swd_regs.sv
`timescale 1ns/1ps
module swd_regs import swd_pkg::*; #(
    parameter int CNT_W       = 10,
    parameter int RST_TIMEOUT = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_cmd_t         cmd,
    input  logic             run_in,
    input  logic             act_in,
    input  logic [CNT_W-1:0] load_in,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] load_val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.run <= 1'b0;
            ctrl.act <= ACT_RESET;
            load_val <= CNT_W'(RST_TIMEOUT);
        end else begin
            if (cmd.wr_ctrl) begin
                ctrl.run <= run_in;
                ctrl.act <= expiry_act_e'(act_in);
            end
            if (cmd.wr_load) begin
                load_val <= load_in;
            end
        end
    end
endmodule

// File: rtl/swd_countdown.sv
`timescale 1ns/1ps
module swd_countdown #(
    parameter int CNT_W       = 10,
    parameter int RST_TIMEOUT = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] remain,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= CNT_W'(RST_TIMEOUT);
            expire <= 1'b0;
        end else begin
            expire <= tick && !reload && (remain == ONE);
            if (reload) begin
                remain <= load_val;
            end else if (tick && (remain != '0)) begin
                remain <= remain - ONE;
            end
        end
    end
endmodule

// File: rtl/sec_watchdog.sv
`timescale 1ns/1ps
module sec_watchdog import swd_pkg::*; #(
    parameter int TICK_CYCLES = 125_000_000,
    parameter int CNT_W       = 10,
    parameter int RST_TIMEOUT = 60,
    parameter int ADDR_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_rst,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              tmr_inhibit,
    output logic              rst_req,
    output logic              pwroff_req
);
    bus_cmd_t         cmd_w;
    ctrl_t            ctrl_w;
    logic [CNT_W-1:0] load_w;
    logic [CNT_W-1:0] remain_w;
    logic             active_w;
    logic             reload_w;
    logic             tick_w;
    logic             expire_w;
    logic             fired_q;
    logic             unused_bits;

    assign unused_bits = ^{bus_wdata[REG_W-1:CNT_W], bus_addr};

    assign cmd_w    = decode_write(bus_wen, bus_addr[SEL_BIT],
                                   bus_wdata[KICK_BIT], bus_wdata[FIRED_BIT]);
    assign reload_w = cmd_w.kick;
    assign active_w = ctrl_w.run && !tmr_inhibit;

    swd_regs #(.CNT_W(CNT_W), .RST_TIMEOUT(RST_TIMEOUT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd_w),
        .run_in   (bus_wdata[RUN_BIT]),
        .act_in   (bus_wdata[ACT_BIT]),
        .load_in  (bus_wdata[CNT_W-1:0]),
        .ctrl     (ctrl_w),
        .load_val (load_w)
    );

    swd_prescale #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .active  (active_w),
        .restart (reload_w),
        .tick    (tick_w)
    );

    swd_countdown #(.CNT_W(CNT_W), .RST_TIMEOUT(RST_TIMEOUT)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .reload   (reload_w),
        .load_val (load_w),
        .tick     (tick_w),
        .remain   (remain_w),
        .expire   (expire_w)
    );

    // Fired flag: power-on domain only, so a watchdog-caused reset keeps it.
    always_ff @(posedge clk) begin
        if (por_rst) begin
            fired_q <= 1'b0;
        end else if (expire_w) begin
            fired_q <= 1'b1;
        end else if (cmd_w.clr_fired) begin
            fired_q <= 1'b0;
        end
    end

    assign rst_req    = expire_w && (ctrl_w.act == ACT_RESET);
    assign pwroff_req = expire_w && (ctrl_w.act == ACT_POWEROFF);

    always_comb begin
        if (bus_addr[SEL_BIT]) begin
            bus_rdata = {{(REG_W-CNT_W){1'b0}}, load_w};
        end else begin
            bus_rdata = pack_ctrl(ctrl_w, fired_q, tmr_inhibit);
        end
    end
endmodule

// File: rtl/swd_chk.sv
`timescale 1ns/1ps
module swd_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             por_rst,
    input logic             rst_req,
    input logic             pwroff_req,
    input logic             active,
    input logic             reload,
    input logic [CNT_W-1:0] remain,
    input logic [CNT_W-1:0] load_val,
    input logic             fired
);
    assert_one_action_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rst_req, pwroff_req}));

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (rst_req || pwroff_req) |=> !(rst_req || pwroff_req));

    assert_expire_when_active_R4: assert property (@(posedge clk) disable iff (rst)
        (rst_req || pwroff_req) |-> $past(active));

    assert_trigger_loads_R3: assert property (@(posedge clk) disable iff (rst)
        reload |=> (remain == $past(load_val)));

    assert_frozen_count_R6: assert property (@(posedge clk) disable iff (rst)
        (!active && !reload) |=> $stable(remain));

    assert_fired_sets_R8: assert property (@(posedge clk) disable iff (por_rst)
        (rst_req || pwroff_req) |=> fired);
endmodule

bind sec_watchdog swd_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .por_rst    (por_rst),
    .rst_req    (rst_req),
    .pwroff_req (pwroff_req),
    .active     (active_w),
    .reload     (reload_w),
    .remain     (remain_w),
    .load_val   (load_w),
    .fired      (fired_q)
);

// File: tb/sim_sec_watchdog.sv
`timescale 1ns/1ps
module sim_sec_watchdog;
    localparam int T      = 8;
    localparam int K_RST  = 1;
    localparam int K_PWR  = 2;
    localparam logic [2:0] A_CTL = 3'd0;
    localparam logic [2:0] A_CNT = 3'd4;

    typedef struct {
        int     kind;
        longint at;
        string  req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por_rst = 1'b1;
    logic        bus_wen = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tmr_inhibit = 1'b0;
    logic        rst_req;
    logic        pwroff_req;

    int     n_chk = 0;
    int     n_err = 0;
    int     n_req = 0;
    longint cyc = 0;
    exp_t   exp_q[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    sec_watchdog #(.TICK_CYCLES(T)) u0 (
        .clk(clk), .rst(rst), .por_rst(por_rst), .bus_wen(bus_wen),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_inhibit(tmr_inhibit), .rst_req(rst_req), .pwroff_req(pwroff_req)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, output longint at);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        at = cyc + 1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp,
                          input string req, input string what);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(bus_rdata == exp, req, what, bus_rdata, exp);
    endtask

    task automatic expect_req(input int kind, input longint at, input string req);
        exp_t e;
        e.kind = kind; e.at = at; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares every observed request against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (rst_req || pwroff_req)) begin
                int kind;
                kind = {30'd0, pwroff_req, rst_req};
                n_req++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected request kind", kind, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(kind == e.kind, e.req, "request kind", kind, e.kind);
                    chk(cyc == e.at, e.req, "request cycle", cyc, e.at);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        longint w;
        longint e;
        int     n0;
        idle(5);
        rst = 1'b0; por_rst = 1'b0;

        // R1 reset state
        rd_chk(A_CTL, 32'h0, "R1", "control after reset");
        rd_chk(A_CNT, 32'd60, "R1", "count after reset");
        chk(!rst_req && !pwroff_req, "R1", "requests after reset",
            {rst_req, pwroff_req}, 0);

        // R2 field widths, R3 trigger reads 0 and stopped trigger only reloads
        wr(A_CNT, 32'hFFFF_FFFF, w);
        rd_chk(A_CNT, 32'h3FF, "R2", "count width");
        wr(A_CTL, 32'hFFFF_FFFE, w);
        rd_chk(A_CTL, 32'h4, "R2", "control fields and kick reads 0 (R3)");
        idle(40);
        wr(A_CTL, 32'h0, w);

        // R7 inhibit visible in bit 3
        tmr_inhibit = 1'b1;
        rd_chk(A_CTL, 32'h8, "R7", "inhibit status bit");
        tmr_inhibit = 1'b0;

        // R4 / R5 reset action, timeout 3 s
        wr(A_CNT, 32'd3, w);
        wr(A_CTL, 32'h81, w);
        expect_req(K_RST, w + 3 * T, "R4");
        idle(30);
        rd_chk(A_CTL, 32'h3, "R8", "fired set after expiry");
        wr(A_CTL, 32'h01, w);
        rd_chk(A_CTL, 32'h3, "R8", "write 0 keeps fired");
        wr(A_CTL, 32'h02, w);
        rd_chk(A_CTL, 32'h0, "R8", "write 1 clears fired");

        // R5 power-off action, R8 flag across rst and por_rst
        wr(A_CNT, 32'd2, w);
        wr(A_CTL, 32'h85, w);
        expect_req(K_PWR, w + 2 * T, "R5");
        idle(20);
        rst = 1'b1; idle(2); rst = 1'b0;
        rd_chk(A_CTL, 32'h2, "R8", "fired survives rst");
        rd_chk(A_CNT, 32'd60, "R1", "count after rst");
        por_rst = 1'b1; idle(2); por_rst = 1'b0;
        rd_chk(A_CTL, 32'h0, "R8", "por_rst clears fired");

        // R6 stop freezes, resume continues
        wr(A_CNT, 32'd2, w);
        wr(A_CTL, 32'h81, w);
        idle(9);
        wr(A_CTL, 32'h00, w);
        idle(40);
        wr(A_CTL, 32'h01, w);
        expect_req(K_RST, w + T, "R6");
        idle(16);
        wr(A_CTL, 32'h02, w);

        // R7 inhibit freezes the countdown
        wr(A_CNT, 32'd2, w);
        wr(A_CTL, 32'h81, w);
        tmr_inhibit = 1'b1;
        idle(40);
        rd_chk(A_CTL, 32'h9, "R7", "inhibit while running");
        @(negedge clk);
        tmr_inhibit = 1'b0;
        e = cyc;
        expect_req(K_RST, e + 2 * T, "R7");
        idle(24);
        wr(A_CTL, 32'h02, w);

        // R10 periodic triggers keep it quiet
        n0 = n_req;
        wr(A_CNT, 32'd2, w);
        wr(A_CTL, 32'h81, w);
        for (int i = 0; i < 5; i++) begin
            idle(10);
            wr(A_CTL, 32'h81, w);
        end
        wr(A_CTL, 32'h00, w);
        chk(n_req == n0, "R10", "requests while kicked", n_req, n0);

        // R9 zero load never expires
        wr(A_CNT, 32'd0, w);
        wr(A_CTL, 32'h81, w);
        idle(60);
        chk(n_req == n0, "R9", "requests with zero load", n_req, n0);
        wr(A_CTL, 32'h00, w);

        idle(4);
        chk(exp_q.size() == 0, "R4", "expected requests left", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule